// File: doc/BRIEF.md
# SPI Burst Register Port

This block is an SPI target that gives an external host access to a bank of 128 eight-bit registers. The host pulls chip select low to open a frame and clocks bytes in mode 0 (data sampled on the rising serial clock, changed on the falling one), most significant bit first. The first byte of every frame is a command: it names a register and says whether the frame reads or writes. Each byte that follows is written to, or read from, that register and then the next ones in turn. Raising chip select closes the frame and drops any burst. The next frame starts again from a new command. A burst never wraps past register 127.

A window of registers is guarded. Writes to it must be single-register frames, and a guarded write must not come soon after an earlier guarded write. The block counts system-clock cycles of chip-select-high time before each frame. A guarded write that breaks either rule is discarded and a sticky error flag is raised. The serial inputs are brought into the system clock domain through synchronizers. The register bank sits outside the block, behind one-cycle read and write strobes with a combinational read-data return.

Top module: `spi_rp_top`

## Requirements
- R1: While reset is held, `miso_oe`, `reg_wr`, `reg_rd` and `prot_err` are all 0.
- R2: `miso_oe` is 1 while a frame is open. It returns to 0 within a few system clocks after chip select rises.
- R3: The first complete byte of a frame is the command. Bits 7:1 give the start register and bit 0 gives the direction (1 = read, 0 = write). The byte is taken MSB first, sampled on rising `sclk`.
- R4: In a write frame, data byte k (k = 0, 1, ...) produces one `reg_wr` pulse to register start+k, with `reg_wdata` equal to that byte.
- R5: In a read frame, data byte k drives the content of register start+k on `miso`, MSB first, with each bit changing after a falling `sclk`. Every register fetch raises `reg_rd` for one cycle.
- R6: A burst stops at the end of the page. Write bytes aimed past register 127 are discarded, and read bytes past register 127 return 0x00.
- R7: When chip select rises, an incomplete byte is discarded with no write. The next frame's first byte is decoded as a new command.
- R8: A write to the guarded window [`PROT_LO`, `PROT_HI`] that is data byte 1 or later of its frame is discarded and sets `prot_err`.
- R9: Each frame start samples the chip-select-high time that came before it. If a guarded write has been accepted since the last frame whose preceding high time reached `MIN_GAP` cycles, a guarded write in a frame with a shorter gap is discarded and sets `prot_err`. A frame with a long enough gap is allowed its guarded write.
- R10: `prot_err` stays at 1 until reset, through any later frames.
- R11: A read frame never raises `reg_wr`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial clock from the host |
| cs_n | input | 1 | Chip select, active low |
| mosi | input | 1 | Serial data from the host |
| miso | output | 1 | Serial data to the host |
| miso_oe | output | 1 | Output enable for `miso` (0 = released) |
| reg_addr | output | 7 | Register index for the current access |
| reg_wr | output | 1 | One-cycle write strobe |
| reg_wdata | output | 8 | Write data |
| reg_rd | output | 1 | One-cycle read strobe |
| reg_rdata | input | 8 | Read data from the bank, valid in the `reg_rd` cycle |
| prot_err | output | 1 | Sticky flag for a discarded guarded write |

## Verification
The hardest state to reach from the pins is the guard's memory of a recent guarded write. It only shows up when a later frame starts after a chip-select-high time below the threshold. The bench reaches it with ordered frames whose high times it sets on purpose: far below the threshold, then far above it. Between these it places unguarded frames, which either keep the memory or clear it. Each step is checked through the register contents and the error flag.

// File: rtl/spi_rp_pkg.sv
package spi_rp_pkg;
  localparam int ADDR_W = 7;
  localparam int DATA_W = 8;

  typedef logic [ADDR_W-1:0] reg_idx_t;
  typedef logic [DATA_W-1:0] byte_t;
  // extra top bit marks a cursor that has run past the last register
  typedef logic [ADDR_W:0]   cursor_t;

  typedef struct packed {
    reg_idx_t idx;
    logic     is_read;
  } cmd_t;

  function automatic cmd_t decode_cmd(byte_t b);
    cmd_t c;
    c.idx     = b[7:1];
    c.is_read = b[0];
    return c;
  endfunction

  function automatic cursor_t advance(cursor_t c);
    if (c[ADDR_W]) return c;
    return c + cursor_t'(1);
  endfunction

  function automatic logic in_window(reg_idx_t a, reg_idx_t lo, reg_idx_t hi);
    return (a >= lo) && (a <= hi);
  endfunction
endpackage

// File: rtl/spi_rp_sync.sv
module spi_rp_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 3,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  logic [WIDTH-1:0] st [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) st[i] <= RST_VAL;
    end else begin
      st[0] <= d;
      for (int i = 1; i < STAGES; i++) st[i] <= st[i-1];
    end
  end

  assign q = st[STAGES-1];
endmodule

// File: rtl/spi_rp_shift.sv
module spi_rp_shift (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk_s,
  input  logic       cs_s_n,
  input  logic       mosi_s,
  input  logic       load_en,
  input  logic [7:0] load_val,
  output logic       frame_start,
  output logic       byte_done,
  output logic [7:0] rx_byte,
  output logic       miso,
  output logic       miso_oe
);
  logic       sclk_d, cs_d, miso_q;
  logic [2:0] bit_cnt;
  logic [7:0] rx_sh, tx_sh;
  logic       sclk_rise, sclk_fall, frame_end;

  assign sclk_rise   = ~cs_s_n & sclk_s & ~sclk_d;
  assign sclk_fall   = ~cs_s_n & ~sclk_s & sclk_d;
  assign frame_start = cs_d & ~cs_s_n;
  assign frame_end   = ~cs_d & cs_s_n;
  assign byte_done   = sclk_rise && (bit_cnt == 3'd7);
  assign rx_byte     = {rx_sh[6:0], mosi_s};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_d  <= 1'b0;
      cs_d    <= 1'b1;
      bit_cnt <= '0;
      rx_sh   <= '0;
      tx_sh   <= '0;
      miso_q  <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      cs_d   <= cs_s_n;
      if (frame_start || frame_end) begin
        bit_cnt <= '0;
        rx_sh   <= '0;
        tx_sh   <= '0;
        miso_q  <= 1'b0;
      end else begin
        if (sclk_rise) begin
          rx_sh   <= rx_byte;
          bit_cnt <= bit_cnt + 3'd1;
          if (load_en) tx_sh <= load_val;
        end
        if (sclk_fall) begin
          miso_q <= tx_sh[7];
          tx_sh  <= {tx_sh[6:0], 1'b0};
        end
      end
    end
  end

  assign miso    = miso_q;
  assign miso_oe = ~cs_d;
endmodule

// File: rtl/spi_rp_guard.sv
module spi_rp_guard
  import spi_rp_pkg::*;
#(
  parameter int MIN_GAP = 100,
  parameter int PROT_LO = 40,
  parameter int PROT_HI = 60
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     cs_s_n,
  input  logic     frame_start,
  input  logic     wr_req,
  input  reg_idx_t wr_idx,
  input  logic     first_data,
  output logic     wr_ok,
  output logic     wr_drop,
  output logic     prot_err
);
  localparam int GAP_W = $clog2(MIN_GAP + 1);
  localparam logic [GAP_W-1:0] GAP_LIM = GAP_W'(MIN_GAP);

  logic [GAP_W-1:0] gap_cnt;
  logic             hot, err_q, gap_met, guarded;

  assign gap_met = gap_cnt >= GAP_LIM;
  assign guarded = in_window(wr_idx, reg_idx_t'(PROT_LO), reg_idx_t'(PROT_HI));
  assign wr_drop = wr_req & guarded & (~first_data | hot);
  assign wr_ok   = wr_req & ~wr_drop;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gap_cnt <= GAP_LIM;
      hot     <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      if (frame_start) begin
        gap_cnt <= '0;
        if (gap_met) hot <= 1'b0;
      end else if (cs_s_n && !gap_met) begin
        gap_cnt <= gap_cnt + 1'b1;
      end
      if (wr_ok && guarded) hot <= 1'b1;
      err_q <= err_q | wr_drop;
    end
  end

  assign prot_err = err_q;
endmodule

// File: rtl/spi_rp_seq.sv
module spi_rp_seq
  import spi_rp_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     frame_start,
  input  logic     byte_done,
  input  byte_t    rx_byte,
  input  byte_t    reg_rdata,
  input  logic     wr_ok,
  output logic     load_en,
  output byte_t    load_val,
  output reg_idx_t reg_addr,
  output logic     reg_rd,
  output logic     reg_wr,
  output byte_t    reg_wdata,
  output logic     wr_req,
  output reg_idx_t wr_idx,
  output logic     first_data,
  output logic     rd_mode,
  output logic     past_end
);
  logic    have_cmd, rd_q, first_q;
  cursor_t cur, nxt;
  cmd_t    cmd;

  assign cmd = decode_cmd(rx_byte);
  assign nxt = advance(cur);

  always_comb begin
    load_en  = 1'b0;
    load_val = '0;
    reg_rd   = 1'b0;
    wr_req   = 1'b0;
    reg_addr = cur[ADDR_W-1:0];
    if (byte_done) begin
      if (!have_cmd) begin
        if (cmd.is_read) begin
          reg_rd   = 1'b1;
          reg_addr = cmd.idx;
          load_en  = 1'b1;
          load_val = reg_rdata;
        end
      end else if (rd_q) begin
        load_en = 1'b1;
        if (!nxt[ADDR_W]) begin
          reg_rd   = 1'b1;
          reg_addr = nxt[ADDR_W-1:0];
          load_val = reg_rdata;
        end
      end else begin
        wr_req = ~cur[ADDR_W];
      end
    end
  end

  assign reg_wr     = wr_ok;
  assign reg_wdata  = rx_byte;
  assign wr_idx     = cur[ADDR_W-1:0];
  assign first_data = first_q;
  assign rd_mode    = rd_q;
  assign past_end   = cur[ADDR_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      have_cmd <= 1'b0;
      rd_q     <= 1'b0;
      first_q  <= 1'b0;
      cur      <= '0;
    end else if (frame_start) begin
      have_cmd <= 1'b0;
      rd_q     <= 1'b0;
      first_q  <= 1'b0;
      cur      <= '0;
    end else if (byte_done) begin
      if (!have_cmd) begin
        have_cmd <= 1'b1;
        rd_q     <= cmd.is_read;
        cur      <= {1'b0, cmd.idx};
        first_q  <= 1'b1;
      end else begin
        cur     <= nxt;
        first_q <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/spi_rp_top.sv
module spi_rp_top
  import spi_rp_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int MIN_GAP     = 100,
  parameter int PROT_LO     = 40,
  parameter int PROT_HI     = 60
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       sclk,
  input  logic       cs_n,
  input  logic       mosi,
  output logic       miso,
  output logic       miso_oe,
  output logic [6:0] reg_addr,
  output logic       reg_wr,
  output logic [7:0] reg_wdata,
  output logic       reg_rd,
  input  logic [7:0] reg_rdata,
  output logic       prot_err
);
  logic [2:0] pins_s;
  logic       sclk_s, cs_s_n, mosi_s;
  logic       frame_start, byte_done, load_en;
  byte_t      rx_byte, load_val;
  logic       wr_req, wr_ok, wr_drop, first_data, rd_mode, past_end;
  reg_idx_t   wr_idx;

  spi_rp_sync #(.STAGES(SYNC_STAGES), .WIDTH(3), .RST_VAL(3'b010)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({mosi, cs_n, sclk}), .q(pins_s)
  );
  assign sclk_s = pins_s[0];
  assign cs_s_n = pins_s[1];
  assign mosi_s = pins_s[2];

  spi_rp_shift u_shift (
    .clk(clk), .rst_n(rst_n), .sclk_s(sclk_s), .cs_s_n(cs_s_n), .mosi_s(mosi_s),
    .load_en(load_en), .load_val(load_val), .frame_start(frame_start),
    .byte_done(byte_done), .rx_byte(rx_byte), .miso(miso), .miso_oe(miso_oe)
  );

  spi_rp_seq u_seq (
    .clk(clk), .rst_n(rst_n), .frame_start(frame_start), .byte_done(byte_done),
    .rx_byte(rx_byte), .reg_rdata(reg_rdata), .wr_ok(wr_ok), .load_en(load_en),
    .load_val(load_val), .reg_addr(reg_addr), .reg_rd(reg_rd), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .wr_req(wr_req), .wr_idx(wr_idx),
    .first_data(first_data), .rd_mode(rd_mode), .past_end(past_end)
  );

  spi_rp_guard #(.MIN_GAP(MIN_GAP), .PROT_LO(PROT_LO), .PROT_HI(PROT_HI)) u_guard (
    .clk(clk), .rst_n(rst_n), .cs_s_n(cs_s_n), .frame_start(frame_start),
    .wr_req(wr_req), .wr_idx(wr_idx), .first_data(first_data),
    .wr_ok(wr_ok), .wr_drop(wr_drop), .prot_err(prot_err)
  );
endmodule

// File: rtl/spi_rp_checker.sv
module spi_rp_checker #(
  parameter int PROT_LO = 40,
  parameter int PROT_HI = 60
) (
  input logic       clk,
  input logic       rst_n,
  input logic       cs_s_n,
  input logic       miso_oe,
  input logic       frame_start,
  input logic       byte_done,
  input logic       reg_wr,
  input logic       reg_rd,
  input logic [6:0] reg_addr,
  input logic       first_data,
  input logic       rd_mode,
  input logic       past_end,
  input logic       wr_drop,
  input logic       prot_err
);
  logic guarded_addr;
  assign guarded_addr = (reg_addr >= 7'(PROT_LO)) && (reg_addr <= 7'(PROT_HI));

  a_r2_oe_on_open: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |=> miso_oe);
  a_r2_oe_released: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cs_s_n) |=> !miso_oe);
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
  a_r6_no_write_past_end: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !past_end);
  a_r7_no_byte_at_open: assert property (@(posedge clk) disable iff (!rst_n)
    frame_start |-> !byte_done);
  a_r8_guarded_single: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && guarded_addr) |-> first_data);
  a_r9_drop_flags: assert property (@(posedge clk) disable iff (!rst_n)
    wr_drop |=> prot_err);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    prot_err |=> prot_err);
  a_r11_no_write_in_read: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !rd_mode);
endmodule

bind spi_rp_top spi_rp_checker #(.PROT_LO(PROT_LO), .PROT_HI(PROT_HI)) chk_i (.*);

// File: tb/spi_rp_top_tb.sv
module spi_rp_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int H          = 6;
  localparam int MIN_GAP    = 100;
  localparam int PLO        = 40;
  localparam int PHI        = 60;

  logic clk = 1'b0;
  logic rst_n, sclk, cs_n, mosi, miso, miso_oe, reg_wr, reg_rd, prot_err;
  logic [6:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic bank_init;

  logic [7:0] mem     [0:127];
  logic [7:0] exp_mem [0:127];
  logic [7:0] tx_buf  [0:15];
  logic [7:0] rx_buf  [0:15];
  logic oe_mid, oe_after, b_hot, exp_err;
  int n_cmp = 0, n_bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_rp_top #(.MIN_GAP(MIN_GAP), .PROT_LO(PLO), .PROT_HI(PHI)) dut_i (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .cs_n(cs_n), .mosi(mosi),
    .miso(miso), .miso_oe(miso_oe), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rd(reg_rd), .reg_rdata(reg_rdata), .prot_err(prot_err)
  );

  // register bank model
  always @(posedge clk) begin
    if (bank_init) begin
      for (int i = 0; i < 128; i++) mem[i] <= 8'(i) ^ 8'hA5;
    end else if (reg_wr) begin
      mem[reg_addr] <= reg_wdata;
    end
  end
  assign reg_rdata = mem[reg_addr];

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic spi_frame(input int nbytes, input int gap, input int tail_bits);
    repeat (gap) @(negedge clk);
    cs_n = 1'b0;
    repeat (H) @(negedge clk);
    oe_mid = miso_oe;
    for (int k = 0; k < nbytes; k++) begin
      logic [7:0] r;
      for (int i = 7; i >= 0; i--) begin
        mosi = tx_buf[k][i];
        repeat (H) @(negedge clk);
        r[i] = miso;
        sclk = 1'b1;
        repeat (H) @(negedge clk);
        sclk = 1'b0;
      end
      rx_buf[k] = r;
    end
    for (int t = 0; t < tail_bits; t++) begin
      mosi = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b1;
      repeat (H) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (H) @(negedge clk);
    cs_n = 1'b1;
    repeat (6) @(negedge clk);
    oe_after = miso_oe;
  endtask

  task automatic write_frame(input int start, input int n, input int gap, input int tail);
    tx_buf[0] = {7'(start), 1'b0};
    for (int k = 0; k < n; k++) tx_buf[k+1] = 8'((start * 7 + k * 13 + 3) & 255);
    if (gap >= MIN_GAP) b_hot = 1'b0;
    for (int k = 0; k < n; k++) begin
      int a;
      logic grd;
      a = start + k;
      if (a <= 127) begin
        grd = (a >= PLO) && (a <= PHI);
        if (grd && (k > 0 || b_hot)) exp_err = 1'b1;
        else begin
          exp_mem[a] = tx_buf[k+1];
          if (grd) b_hot = 1'b1;
        end
      end
    end
    spi_frame(n + 1, gap, tail);
  endtask

  task automatic read_frame(input int start, input int n, input string req);
    tx_buf[0] = {7'(start), 1'b1};
    for (int k = 1; k <= n; k++) tx_buf[k] = 8'hFF;
    b_hot = 1'b0;
    spi_frame(n + 1, 200, 0);
    for (int k = 0; k < n; k++) begin
      logic [7:0] e;
      e = (start + k <= 127) ? exp_mem[start + k] : 8'h00;
      check(req, {24'd0, rx_buf[k+1]}, {24'd0, e});
    end
  endtask

  task automatic mem_check(input string req);
    int bad = 0;
    for (int i = 0; i < 128; i++) if (mem[i] !== exp_mem[i]) bad++;
    check(req, bad, 0);
    check({req, " prot_err"}, {31'd0, prot_err}, {31'd0, exp_err});
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    b_hot = 1'b0;
    exp_err = 1'b0;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    rst_n = 1'b0; sclk = 1'b0; cs_n = 1'b1; mosi = 1'b0; bank_init = 1'b1;
    b_hot = 1'b0; exp_err = 1'b0;
    for (int i = 0; i < 128; i++) exp_mem[i] = 8'(i) ^ 8'hA5;
    repeat (3) @(negedge clk);
    bank_init = 1'b0;
    // R1 reset state
    check("R1 miso_oe", {31'd0, miso_oe}, 0);
    check("R1 reg_wr", {31'd0, reg_wr}, 0);
    check("R1 reg_rd", {31'd0, reg_rd}, 0);
    check("R1 prot_err", {31'd0, prot_err}, 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R4 write bursts over several starts and lengths
    for (int j = 0; j < 7; j++) begin
      int starts [7] = '{0, 9, 20, 64, 70, 90, 110};
      write_frame(starts[j], 2 + (j % 5), 200, 0);
      mem_check("R4 burst write");
      if (j == 0) begin
        check("R2 oe in frame", {31'd0, oe_mid}, 1);
        check("R2 oe after frame", {31'd0, oe_after}, 0);
      end
    end

    // R3 R5 read bursts across the page, R6 at the tail
    for (int s = 0; s < 128; s += 11) read_frame(s, 3, "R5 R3 burst read");
    read_frame(126, 4, "R6 read past end");
    mem_check("R11 read frames write nothing");

    // R6 write running over the page end
    write_frame(125, 5, 200, 0);
    mem_check("R6 write past end");

    // R7 partial byte then new command
    write_frame(80, 1, 200, 4);
    mem_check("R7 partial byte");
    read_frame(80, 2, "R7 new command");

    // R8 guarded registers inside a burst
    do_reset();
    write_frame(38, 4, 200, 0);
    mem_check("R8 guarded in burst");
    do_reset();
    write_frame(PLO, 2, 200, 0);
    mem_check("R8 guarded burst start");

    // R9 R10 gap rule
    do_reset();
    write_frame(45, 1, 200, 0);
    mem_check("R9 first guarded write");
    write_frame(50, 1, 30, 0);
    mem_check("R9 short gap dropped");
    write_frame(70, 1, 30, 0);
    mem_check("R10 sticky, unguarded short gap");
    write_frame(51, 1, 30, 0);
    mem_check("R9 memory kept through unguarded frame");
    write_frame(72, 1, 200, 0);
    write_frame(52, 1, 30, 0);
    mem_check("R9 long gap clears memory");
    write_frame(PHI, 1, 200, 0);
    mem_check("R10 sticky after accepted write");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (180000) @(posedge clk);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule